// File: doc/BRIEF.md
# Switchable-Polynomial 16-Stage Feedback Register

This block is a 16-stage, one-bit-per-stage feedback shift register whose tap set is not fixed: it is taken from a built-in table of eight primitive degree-16 polynomials. A 3-bit pointer selects the table entry. A round counter counts steps, and on every fifteenth step the pointer advances by an external random bit, modulo 8. The block is one component of a lightweight stream generator. Its top stage feeds the generator output, and its bottom stage feeds a neighbouring nonlinear combiner.

A key load fills the register and restarts both the pointer and the round counter. A small control machine has two states. `PH_IDLE` is the state after reset; step requests are ignored there. `PH_RUN` is the operating state. The transition `PH_IDLE -> PH_RUN` happens on a key load. `PH_RUN -> PH_RUN` is taken on every later cycle, and a reload in this state restarts the pointer and the counter. While the mixing mode is active, an injected bit from the rest of the generator is XORed into the feedback.

Top module: `dfl_lfsr16`

## Requirements
- R1: After reset the register holds all zeros, the pointer is 0, the round counter is 0, the machine is in `PH_IDLE`, and both outputs read 0.
- R2: When `load_en` is high on a clock edge, stage i takes `load_key[i]`, and the pointer and round counter are cleared. Load has priority over a step in the same cycle and is accepted in either state.
- R3: In `PH_IDLE` (no key loaded since reset), `step_en` has no effect on the register, even with mixing and injection active.
- R4: A step in `PH_RUN` shifts stage i+1 into stage i for i = 0..14 and writes the feedback bit into stage 15. The feedback bit is the XOR of every stage s whose exponent s appears in the current entry, where exponent 0 means stage 0. Without a step the register and pointer hold.
- R5: The table, indexed by the pointer, lists the exponents below x^16 for each entry: 0:{11,7,6,5,1,0}, 1:{11,7,6,5,4,0}, 2:{11,7,6,5,4,3,1,0}, 3:{11,10,6,5,3,0}, 4:{11,6,5,0}, 5:{13,11,10,6,5,0}, 6:{11,10,6,5,1,0}, 7:{11,10,6,5,4,3,1,0}.
- R6: The round counter counts steps 0..14. On the step taken with the counter at 14, the counter wraps to 0 and the pointer becomes (pointer + `rnd_bit`) mod 8. That step still uses the old entry. `rnd_bit` has no effect on any other step.
- R7: On a step with `init_mode` high, `inj_bit` is XORed into the feedback bit. With `init_mode` low, `inj_bit` has no effect.
- R8: A step without injection never turns a nonzero register into all zeros, whatever the entry.
- R9: `out_hi` shows stage 15 and `out_lo` shows stage 0 of the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance the register by one step |
| load_en | input | 1 | Load the key and restart the pointer and counter |
| load_key | input | 16 | Key word, bit i goes to stage i |
| rnd_bit | input | 1 | External random bit, added to the pointer at each wrap |
| init_mode | input | 1 | Mixing mode: enables injection into the feedback |
| inj_bit | input | 1 | Bit XORed into the feedback while mixing |
| out_hi | output | 1 | Stage 15 |
| out_lo | output | 1 | Stage 0 |

## Verification
The bench builds the block with its default values: 16 stages, eight table entries and a 15-step round. A round that short brings all eight table entries within reach of one 120-step walk, driven with the random bit held at 1. The same setting exposes the pointer wrap from 7 back to 0, a reload in the middle of a round, and the placement of the random bit at every wrap, all within a few hundred steps.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
    localparam int REG_W  = 16;
    localparam int POLY_N = 8;
    localparam int SEL_W  = $clog2(POLY_N);

    typedef logic [REG_W-1:0] state_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // tap masks: bit e set when x^e is a term below x^16
    localparam state_t TAP_TABLE [POLY_N] = '{
        16'h08E3,
        16'h08F1,
        16'h08FB,
        16'h0C69,
        16'h0861,
        16'h2C61,
        16'h0C63,
        16'h0C7B
    };
endpackage

// File: rtl/dfl_poly_rom.sv
module dfl_poly_rom
    import dfl_pkg::*;
(
    input  sel_t   sel,
    output state_t taps
);
    assign taps = TAP_TABLE[sel];
endmodule

// File: rtl/dfl_round_ctr.sv
module dfl_round_ctr
    import dfl_pkg::*;
#(
    parameter int ROUND_LEN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic rnd,
    output sel_t sel
);
    localparam int CW = (ROUND_LEN > 1) ? $clog2(ROUND_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(ROUND_LEN - 1);

    logic [CW-1:0] cnt_q;
    sel_t          sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (step) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                sel_q <= sel_q + sel_t'(rnd);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/dfl_shift_reg.sv
module dfl_shift_reg
    import dfl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  state_t key,
    input  logic   step,
    input  state_t taps,
    input  logic   inj,
    output state_t state
);
    state_t st_q;
    state_t tapped;
    logic   fb;

    genvar gi;
    generate
        for (gi = 0; gi < REG_W; gi++) begin : g_tap
            assign tapped[gi] = st_q[gi] & taps[gi];
        end
    endgenerate

    assign fb = (^tapped) ^ inj;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load) begin
            st_q <= key;
        end else if (step) begin
            st_q <= {fb, st_q[REG_W-1:1]};
        end
    end

    assign state = st_q;
endmodule

// File: rtl/dfl_lfsr16.sv
module dfl_lfsr16
    import dfl_pkg::*;
#(
    parameter int ROUND_LEN = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             load_en,
    input  logic [REG_W-1:0] load_key,
    input  logic             rnd_bit,
    input  logic             init_mode,
    input  logic             inj_bit,
    output logic             out_hi,
    output logic             out_lo
);
    phase_e phase_q, phase_d;
    logic   running;
    logic   step_go;
    logic   inj_go;
    sel_t   poly_sel;
    state_t taps;
    state_t state;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (load_en) phase_d = PH_RUN;
            PH_RUN:  phase_d = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        running = 1'b0;
        unique case (phase_q)
            PH_IDLE: running = 1'b0;
            PH_RUN:  running = 1'b1;
        endcase
        step_go = running & step_en & ~load_en;
        inj_go  = init_mode & inj_bit;
    end

    dfl_round_ctr #(.ROUND_LEN(ROUND_LEN)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_en),
        .step  (step_go),
        .rnd   (rnd_bit),
        .sel   (poly_sel)
    );

    dfl_poly_rom u_rom (
        .sel  (poly_sel),
        .taps (taps)
    );

    dfl_shift_reg u_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .key   (load_key),
        .step  (step_go),
        .taps  (taps),
        .inj   (inj_go),
        .state (state)
    );

    assign out_hi = state[REG_W-1];
    assign out_lo = state[0];
endmodule

// File: rtl/dfl_lfsr16_chk.sv
module dfl_lfsr16_chk
    import dfl_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   load_en,
    input state_t load_key,
    input logic   step_en,
    input logic   rnd_bit,
    input logic   init_mode,
    input logic   running,
    input logic   step_go,
    input state_t state,
    input sel_t   sel
);
    AST_LOAD_TAKES_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> state == $past(load_key));                               // R2
    AST_LOAD_CLEARS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> sel == '0);                                              // R2
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load_en) |=> $stable(state));                          // R3
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> ($stable(state) && $stable(sel)));        // R4
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        step_go |=> state[REG_W-2:0] == $past(state[REG_W-1:1]));            // R4
    AST_SEL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && rnd_bit) |=> ((sel == $past(sel)) ||
                                  (sel == sel_t'($past(sel) + 1'b1))));      // R6
    AST_SEL_NO_RND: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && !rnd_bit) |=> $stable(sel));                             // R6
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && !init_mode && state != '0) |=> state != '0);             // R8
endmodule

bind dfl_lfsr16 dfl_lfsr16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_key  (load_key),
    .step_en   (step_en),
    .rnd_bit   (rnd_bit),
    .init_mode (init_mode),
    .running   (running),
    .step_go   (step_go),
    .state     (state),
    .sel       (poly_sel)
);

// File: tb/dfl_lfsr16_tb_top.sv
module dfl_lfsr16_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_key = '0;
    logic        rnd_bit = 1'b0;
    logic        init_mode = 1'b0;
    logic        inj_bit = 1'b0;
    logic        out_hi;
    logic        out_lo;

    int total = 0;
    int bad   = 0;

    logic [15:0] m_st = '0;
    logic [2:0]  m_sel = '0;
    int          m_cnt = 0;
    bit          m_loaded = 0;

    always #10 clk = ~clk;

    dfl_lfsr16 dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
        .load_key(load_key), .rnd_bit(rnd_bit), .init_mode(init_mode),
        .inj_bit(inj_bit), .out_hi(out_hi), .out_lo(out_lo)
    );

    // R5: exponent sets written as tap masks
    function automatic logic [15:0] tap_mask(input logic [2:0] s);
        case (s)
            3'd0: tap_mask = (1<<11)|(1<<7)|(1<<6)|(1<<5)|(1<<1)|1;
            3'd1: tap_mask = (1<<11)|(1<<7)|(1<<6)|(1<<5)|(1<<4)|1;
            3'd2: tap_mask = (1<<11)|(1<<7)|(1<<6)|(1<<5)|(1<<4)|(1<<3)|(1<<1)|1;
            3'd3: tap_mask = (1<<11)|(1<<10)|(1<<6)|(1<<5)|(1<<3)|1;
            3'd4: tap_mask = (1<<11)|(1<<6)|(1<<5)|1;
            3'd5: tap_mask = (1<<13)|(1<<11)|(1<<10)|(1<<6)|(1<<5)|1;
            3'd6: tap_mask = (1<<11)|(1<<10)|(1<<6)|(1<<5)|(1<<1)|1;
            default: tap_mask = (1<<11)|(1<<10)|(1<<6)|(1<<5)|(1<<4)|(1<<3)|(1<<1)|1;
        endcase
    endfunction

    task automatic check_bits(input string tag, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_model(input string tag);
        check_bits(tag, {out_hi, out_lo}, {m_st[15], m_st[0]});
    endtask

    task automatic do_step(input logic r, input logic im, input logic inj, input string tag);
        logic fb;
        @(negedge clk);
        step_en = 1'b1; rnd_bit = r; init_mode = im; inj_bit = inj;
        @(posedge clk);
        #1;
        step_en = 1'b0; rnd_bit = 1'b0; init_mode = 1'b0; inj_bit = 1'b0;
        if (m_loaded) begin
            fb = (^(m_st & tap_mask(m_sel))) ^ (im & inj);
            m_st = {fb, m_st[15:1]};
            if (m_cnt == 14) begin
                m_cnt = 0;
                m_sel = m_sel + {2'b00, r};
            end else begin
                m_cnt++;
            end
        end
        #5;
        check_model(tag);
    endtask

    task automatic do_load(input logic [15:0] key, input logic with_step, input string tag);
        @(negedge clk);
        load_en = 1'b1; load_key = key; step_en = with_step;
        rnd_bit = 1'b1; init_mode = 1'b1; inj_bit = 1'b1;
        @(posedge clk);
        #1;
        load_en = 1'b0; step_en = 1'b0; rnd_bit = 1'b0; init_mode = 1'b0; inj_bit = 1'b0;
        m_st = key; m_sel = '0; m_cnt = 0; m_loaded = 1;
        #5;
        check_model(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_bits("R1 in reset", {out_hi, out_lo}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check_bits("R1 after release", {out_hi, out_lo}, 2'b00);
    endtask

    task automatic t_idle_ignored();
        for (int i = 0; i < 3; i++) do_step(1'b1, 1'b1, 1'b1, "R3 step before load");
    endtask

    task automatic t_load();
        do_load(16'hA5C3, 1'b0, "R2 R9 load key");
        check_bits("R9 out map", {out_hi, out_lo}, 2'b11);
        do_load(16'h8000, 1'b1, "R2 load beats step");
        check_bits("R2 priority", {out_hi, out_lo}, 2'b10);
    endtask

    task automatic t_walk_table();
        do_load(16'h0001, 1'b0, "R2 walk load");
        for (int i = 0; i < 8 * 15 + 20; i++) do_step(1'b1, 1'b0, 1'b0, "R5 R6 table walk");
    endtask

    task automatic t_rnd_zero();
        do_load(16'hBEEF, 1'b0, "R2 rnd zero load");
        for (int i = 0; i < 45; i++) do_step(1'b0, 1'b0, 1'b0, "R6 rnd held low");
    endtask

    task automatic t_rnd_only_at_wrap();
        do_load(16'h1234, 1'b0, "R2 wrap load");
        for (int i = 0; i < 75; i++)
            do_step((m_cnt != 14) || (i > 40), 1'b0, 1'b0, "R6 rnd only at wrap");
    endtask

    task automatic t_hold();
        do_load(16'h4C1D, 1'b0, "R2 hold load");
        for (int i = 0; i < 5; i++) do_step(1'b1, 1'b0, 1'b0, "R4 pre-hold");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rnd_bit = 1'b1; init_mode = 1'b1; inj_bit = 1'b1;
            @(posedge clk);
            #1;
            rnd_bit = 1'b0; init_mode = 1'b0; inj_bit = 1'b0;
            #5;
            check_model("R4 hold without step");
        end
        for (int i = 0; i < 20; i++) do_step(1'b1, 1'b0, 1'b0, "R4 resume after hold");
    endtask

    task automatic t_inject();
        do_load(16'h0F0F, 1'b0, "R2 inject load");
        for (int i = 0; i < 30; i++)
            do_step(1'b1, 1'b1, logic'(((i & 1) ^ ((i >> 2) & 1)) != 0), "R7 mixing inject");
        for (int i = 0; i < 20; i++) do_step(1'b1, 1'b0, 1'b1, "R7 inject ignored");
    endtask

    task automatic t_reload();
        do_load(16'h2222, 1'b0, "R2 first load");
        for (int i = 0; i < 7; i++) do_step(1'b1, 1'b0, 1'b0, "R6 before reload");
        do_load(16'h7777, 1'b0, "R2 reload mid round");
        for (int i = 0; i < 25; i++) do_step(1'b1, 1'b0, 1'b0, "R6 counter restarted");
    endtask

    task automatic t_nonzero();
        logic [15:0] hist;
        hist = '0;
        do_load(16'h0001, 1'b0, "R2 nonzero load");
        for (int i = 0; i < 300; i++) begin
            do_step(logic'((i % 3) == 0), 1'b0, 1'b0, "R8 long run");
            hist = {hist[14:0], out_hi};
        end
        total++;
        if (hist == '0) begin
            bad++;
            $display("FAIL R8 actual=%h expected=nonzero", hist);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_ignored();
        t_load();
        t_walk_table();
        t_rnd_zero();
        t_rnd_only_at_wrap();
        t_hold();
        t_inject();
        t_reload();
        t_nonzero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule